// File: doc/BRIEF.md
# I2C Slave Transmitter Controller

This block is an I2C target that answers a master's read request. It watches SCL and SDA through input synchronizers and decodes START and STOP. It collects the address byte after every START. When the seven address bits name this target and the direction bit asks for a read, it acknowledges. It then shifts data bytes out of a data register, most significant bit first, while the master clocks them in.

Every protocol event sets one interrupt flag and posts an 8-bit status code. While the flag is set, the target pulls SCL low. Software reads the code, loads the next byte and clears the flag through a small register port, which lets the transfer continue. An acknowledge-enable bit in the control register decides how a transfer ends. When it is set, the target keeps sending. When software clears it before releasing the flag, the byte that follows is the final one. After that byte, or after any NACK from the master, the target withdraws. It leaves SDA released, so the master reads all ones, and it goes on tracking START and STOP. A pulse on `arb_lost_i` reports that a master on the same chip lost arbitration. The next own-address read is then tagged with its own code.

Register map (`reg_addr`):
- 0: target address in bits 7:1, general-call enable in bit 0.
- 1: transmit data.
- 2: status, read-only.
- 3: control. Bit 0 is acknowledge-enable (read/write) and bit 1 is the interrupt flag (read-only).
- 4: flag clear. Writing a 1 in bit 0 clears the flag; the register is write-only and reads 0.

Top module: `i2c_tgt_tx`

## Requirements
- R1: After reset the status register reads 0xF8, the control register reads 0x00, `irq` is 0, and both `scl_oe` and `sda_oe` are 0.
- R2: If the address byte's upper seven bits equal register 0 bits 7:1, its last bit is 1 (read) and acknowledge-enable is set, the target pulls SDA low on the ninth clock. It then sets the flag with status 0xA8. Any other address, or the write direction, gets no ACK and no flag.
- R3: An `arb_lost_i` pulse before an own-address read makes that read report 0xB0 instead of 0xA8. A STOP or the reported event consumes the mark, so a later read reports 0xA8.
- R4: While the flag is set, SCL is held low even if the master releases it. Writing 1 to bit 0 of register 4 clears the flag, frees SCL and makes the status read 0xF8.
- R5: After the flag is cleared, the byte in register 1 goes out most significant bit first. SDA changes only while SCL is low.
- R6: A byte sent with acknowledge-enable set that the master ACKs gives status 0xB8.
- R7: A byte the master NACKs gives status 0xC0, and the target leaves the transfer.
- R8: If acknowledge-enable is clear when the flag is cleared, the next byte is the last one. If the master ACKs it, the status is 0xC8.
- R9: After 0xC0 or 0xC8 and a flag clear, the target leaves SDA released: the master reads 0xFF and no flag is raised.
- R10: While acknowledge-enable is clear, neither the own address nor the general call is acknowledged. Setting the bit again restores recognition.
- R11: Address 0x00 with the read bit is acknowledged (status 0xA8) only when register 0 bit 0 is set.
- R12: A repeated START returns the target to address collection, so the following address byte alone decides whether it responds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| arb_lost_i | input | 1 | One-cycle pulse: local master lost arbitration |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt flag |

## Verification
The assertions check the following on every cycle:
- the drive on SDA moves only while the synchronized SCL is low;
- the target never drives SDA while it is not addressed;
- a set flag always comes with a code other than 0xF8;
- the hold state keeps the flag raised;
- an address ACK starts only with acknowledge-enable set;
- acknowledge-enable changes only on a control write.

Only the bench's scenarios can show:
- the full address decode, from a sweep of all 128 addresses with the read bit;
- the serial order of bytes computed in the bench;
- the order of codes through the final-byte, NACK, arbitration-loss and general-call endings;
- that the master reads all ones once the target has withdrawn.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int REG_AW = 3;

  localparam logic [7:0] ST_NOINFO   = 8'hF8;
  localparam logic [7:0] ST_ADR_READ = 8'hA8;
  localparam logic [7:0] ST_ARB_READ = 8'hB0;
  localparam logic [7:0] ST_SENT_ACK = 8'hB8;
  localparam logic [7:0] ST_SENT_NAK = 8'hC0;
  localparam logic [7:0] ST_LAST_ACK = 8'hC8;

  localparam logic [REG_AW-1:0] RG_ADR  = 3'd0;
  localparam logic [REG_AW-1:0] RG_DATA = 3'd1;
  localparam logic [REG_AW-1:0] RG_STAT = 3'd2;
  localparam logic [REG_AW-1:0] RG_CTRL = 3'd3;
  localparam logic [REG_AW-1:0] RG_CLR  = 3'd4;

  typedef enum logic [2:0] {
    S_FREE, S_ADDR, S_AACK, S_HOLD, S_SEND, S_MACK
  } tgt_state_t;

  // rx = {address[6:0], rw}; cfg = {own address[6:0], general-call enable}
  function automatic logic addr_hit(input logic [7:0] rx, input logic [7:0] cfg);
    return rx[0] && ((rx[7:1] == cfg[7:1]) || (cfg[0] && (rx[7:1] == 7'd0)));
  endfunction

  function automatic logic [7:0] done_code(input logic got_ack, input logic was_last);
    if (!got_ack)     return ST_SENT_NAK;
    else if (was_last) return ST_LAST_ACK;
    else               return ST_SENT_ACK;
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [7:0]        status,
  input  logic              flag,
  output logic [7:0]        reg_rdata,
  output logic [7:0]        own_cfg,
  output logic [7:0]        tx_data,
  output logic              ack_en,
  output logic              clr_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_cfg <= 8'h00;
      tx_data <= 8'h00;
      ack_en  <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        RG_ADR:  own_cfg <= reg_wdata;
        RG_DATA: tx_data <= reg_wdata;
        RG_CTRL: ack_en  <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  assign clr_req = reg_we && (reg_addr == RG_CLR) && reg_wdata[0];

  always_comb begin
    case (reg_addr)
      RG_ADR:  reg_rdata = own_cfg;
      RG_DATA: reg_rdata = tx_data;
      RG_STAT: reg_rdata = status;
      RG_CTRL: reg_rdata = {6'd0, flag, ack_en};
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_ACKEN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == RG_CTRL) |=> $stable(ack_en)); // R10

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       arb_lost_i,
  input  logic [7:0] own_cfg,
  input  logic [7:0] tx_data,
  input  logic       ack_en,
  input  logic       clr_req,
  output logic       flag,
  output logic [7:0] status,
  output logic       sda_oe
);
  tgt_state_t state;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic lost_q, last_q, mack_q, go_q;

  // named events
  logic evt_addr_done, evt_hit, evt_release, evt_byte_end;
  assign evt_addr_done = (state == S_ADDR) && scl_fall && (cnt == 4'd8);
  assign evt_hit       = evt_addr_done && ack_en && addr_hit(sh, own_cfg);
  assign evt_release   = flag && clr_req;
  assign evt_byte_end  = (state == S_MACK) && scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_FREE;
      cnt    <= 4'd0;
      sh     <= 8'h00;
      lost_q <= 1'b0;
      last_q <= 1'b0;
      mack_q <= 1'b0;
      go_q   <= 1'b0;
      flag   <= 1'b0;
      status <= ST_NOINFO;
      sda_oe <= 1'b0;
    end else begin
      if (arb_lost_i)    lost_q <= 1'b1;
      else if (bus_stop) lost_q <= 1'b0;

      if (evt_release) begin
        flag   <= 1'b0;
        status <= ST_NOINFO;
      end

      if (bus_start) begin
        state  <= S_ADDR;
        cnt    <= 4'd0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        state  <= S_FREE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (evt_addr_done) begin
              if (evt_hit) begin
                state  <= S_AACK;
                sda_oe <= 1'b1;
              end else begin
                state <= S_FREE;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              flag   <= 1'b1;
              status <= lost_q ? ST_ARB_READ : ST_ADR_READ;
              lost_q <= 1'b0;
              go_q   <= 1'b1;
              state  <= S_HOLD;
            end
          end
          S_HOLD: begin
            if (evt_release) begin
              if (go_q) begin
                sh     <= tx_data;
                last_q <= ~ack_en;
                sda_oe <= ~tx_data[7];
                cnt    <= 4'd0;
                state  <= S_SEND;
              end else begin
                state <= S_FREE;
              end
            end
          end
          S_SEND: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= S_MACK;
              end else begin
                sda_oe <= ~sh[6];
                sh     <= {sh[6:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (evt_byte_end) begin
              flag   <= 1'b1;
              status <= done_code(mack_q, last_q);
              go_q   <= mack_q && !last_q;
              state  <= S_HOLD;
            end
          end
          default: state <= S_FREE;
        endcase
      end
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe) |-> !scl_s); // R5
  AST_FLAG_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> (status != ST_NOINFO)); // R2
  AST_HOLD_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD) |-> flag); // R4
  AST_RELEASE_NOINFO: assert property (@(posedge clk) disable iff (!rst_n)
    evt_release |=> (!flag && status == ST_NOINFO)); // R4
  AST_UNADDRESSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FREE) |-> !sda_oe); // R9
  AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_AACK) |-> $past(ack_en)); // R10

endmodule

// File: rtl/i2c_tgt_tx.sv
module i2c_tgt_tx
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              arb_lost_i,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [7:0] own_cfg, tx_data, status;
  logic ack_en, clr_req, flag;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_tgt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status), .flag(flag), .reg_rdata(reg_rdata),
    .own_cfg(own_cfg), .tx_data(tx_data), .ack_en(ack_en), .clr_req(clr_req)
  );

  i2c_tgt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
    .bus_stop(bus_stop), .arb_lost_i(arb_lost_i), .own_cfg(own_cfg),
    .tx_data(tx_data), .ack_en(ack_en), .clr_req(clr_req), .flag(flag),
    .status(status), .sda_oe(sda_oe)
  );

  assign scl_oe = flag;
  assign irq    = flag;

endmodule

// File: tb/i2c_tgt_tx_tb.sv
module i2c_tgt_tx_tb;
  import i2c_tgt_pkg::*;

  localparam int CLK_P = 10;
  localparam int HB    = 12;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, arb = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic scl_line, sda_line;
  int n_chk = 0, n_fail = 0;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  i2c_tgt_tx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .arb_lost_i(arb),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; tick(HB); scl_up(); tick(HB);
    sda_m = 1'b0; tick(HB); scl_m = 1'b0; tick(HB);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; tick(HB); scl_up(); tick(HB); sda_m = 1'b1; tick(HB);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(HB); scl_up(); tick(HB); scl_m = 1'b0; tick(HB);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(HB); scl_up(); tick(HB/2);
    b = sda_line; tick(HB/2); scl_m = 1'b0; tick(HB);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, output logic ack);
    logic b;
    for (int i = 6; i >= 0; i--) put_bit(a[i]);
    put_bit(rw);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic sw_release(input logic [7:0] d);
    reg_write(RG_DATA, d);
    reg_write(RG_CLR, 8'h01);
  endtask

  // release with a byte, NACK it, check 0xC0, clear, stop
  task automatic finish_nack(input logic [7:0] d, input string req);
    logic [7:0] got, st;
    sw_release(d);
    read_byte(got, 1'b0);
    check({req, " byte"}, got, d);
    reg_read(RG_STAT, st);
    check("R7 nack status", st, ST_SENT_NAK);
    reg_write(RG_CLR, 8'h01);
    m_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd, got, pat;
    logic ak, hit;

    tick(5); rst_n = 1'b1; tick(3);
    // R1 reset state
    reg_read(RG_STAT, rd); check("R1 status", rd, ST_NOINFO);
    reg_read(RG_CTRL, rd); check("R1 ctrl", rd, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 lines", {6'd0, scl_oe, sda_oe}, 8'h00);

    reg_write(RG_ADR, {OWN, 1'b0});
    reg_write(RG_CTRL, 8'h01);

    // R2 sweep of all addresses with the read bit
    for (int a = 0; a < 128; a++) begin
      hit = (a == int'(OWN));
      m_start();
      send_addr(7'(a), 1'b1, ak);
      check("R2 addr ack", {7'd0, ak}, {7'd0, hit});
      check("R2 addr irq", {7'd0, irq}, {7'd0, hit});
      if (hit) begin
        reg_read(RG_STAT, rd); check("R2 status", rd, ST_ADR_READ);
        scl_m = 1'b1; tick(6);
        check("R4 scl held", {7'd0, scl_line}, 8'h00);
        scl_m = 1'b0; tick(2);
        sw_release(8'h96);
        reg_read(RG_STAT, rd); check("R4 status after clear", rd, ST_NOINFO);
        check("R4 irq after clear", {7'd0, irq}, 8'h00);
        read_byte(got, 1'b0);
        check("R5 byte", got, 8'h96);
        reg_read(RG_STAT, rd); check("R7 status", rd, ST_SENT_NAK);
        reg_write(RG_CLR, 8'h01);
      end
      m_stop();
    end

    // R2 write direction to own address
    m_start(); send_addr(OWN, 1'b0, ak);
    check("R2 write dir no ack", {7'd0, ak}, 8'h00);
    check("R2 write dir irq", {7'd0, irq}, 8'h00);
    m_stop();

    // R6 multi-byte stream, then R8 last byte and R9 all ones
    m_start(); send_addr(OWN, 1'b1, ak);
    check("R2 stream ack", {7'd0, ak}, 8'h01);
    for (int i = 0; i < 8; i++) begin
      pat = 8'((i * 37 + 5) ^ ((i % 2 == 1) ? 255 : 0));
      sw_release(pat);
      read_byte(got, 1'b1);
      check("R5 stream byte", got, pat);
      reg_read(RG_STAT, rd); check("R6 ack status", rd, ST_SENT_ACK);
    end
    reg_write(RG_CTRL, 8'h00);
    sw_release(8'h5C);
    read_byte(got, 1'b1);
    check("R8 last byte", got, 8'h5C);
    reg_read(RG_STAT, rd); check("R8 last status", rd, ST_LAST_ACK);
    reg_write(RG_CLR, 8'h01);
    read_byte(got, 1'b1);
    check("R9 ones after last", got, 8'hFF);
    check("R9 no irq", {7'd0, irq}, 8'h00);
    m_stop();

    // R10 acknowledge-enable clear blocks own address
    m_start(); send_addr(OWN, 1'b1, ak);
    check("R10 no ack when disabled", {7'd0, ak}, 8'h00);
    check("R10 no irq when disabled", {7'd0, irq}, 8'h00);
    m_stop();
    reg_write(RG_CTRL, 8'h01);

    // R7 / R9 NACK ending
    m_start(); send_addr(OWN, 1'b1, ak);
    check("R10 ack restored", {7'd0, ak}, 8'h01);
    sw_release(8'h71);
    read_byte(got, 1'b0);
    check("R5 nack byte", got, 8'h71);
    reg_read(RG_STAT, rd); check("R7 nack status", rd, ST_SENT_NAK);
    reg_write(RG_CLR, 8'h01);
    read_byte(got, 1'b1);
    check("R9 ones after nack", got, 8'hFF);
    check("R9 no irq after nack", {7'd0, irq}, 8'h00);
    m_stop();

    // R12 repeated start mid-transfer
    m_start(); send_addr(OWN, 1'b1, ak);
    sw_release(8'h80);
    m_start(); send_addr(7'h11, 1'b1, ak);
    check("R12 other addr after rs", {7'd0, ak}, 8'h00);
    check("R12 no irq after rs", {7'd0, irq}, 8'h00);
    m_start(); send_addr(OWN, 1'b1, ak);
    check("R12 own addr after rs", {7'd0, ak}, 8'h01);
    finish_nack(8'h3B, "R12");

    // R3 arbitration loss
    @(negedge clk); arb = 1'b1; @(negedge clk); arb = 1'b0;
    m_start(); send_addr(OWN, 1'b1, ak);
    check("R3 ack", {7'd0, ak}, 8'h01);
    reg_read(RG_STAT, rd); check("R3 arb status", rd, ST_ARB_READ);
    finish_nack(8'hC3, "R3");
    m_start(); send_addr(OWN, 1'b1, ak);
    reg_read(RG_STAT, rd); check("R3 mark consumed", rd, ST_ADR_READ);
    finish_nack(8'h0F, "R3");

    // R11 general call
    reg_write(RG_ADR, {OWN, 1'b1});
    m_start(); send_addr(7'h00, 1'b1, ak);
    check("R11 gc ack", {7'd0, ak}, 8'h01);
    reg_read(RG_STAT, rd); check("R11 gc status", rd, ST_ADR_READ);
    finish_nack(8'hE7, "R11");
    reg_write(RG_CTRL, 8'h00);
    m_start(); send_addr(7'h00, 1'b1, ak);
    check("R10 gc blocked when disabled", {7'd0, ak}, 8'h00);
    m_stop();
    reg_write(RG_CTRL, 8'h01);
    reg_write(RG_ADR, {OWN, 1'b0});
    m_start(); send_addr(7'h00, 1'b1, ak);
    check("R11 gc off", {7'd0, ak}, 8'h00);
    m_stop();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule